// File: doc/BRIEF.md
# Sleep-State and Reset Qualification Controller

This block sits beside a small 8-bit controller core and decides which clocks run. Three states are named: `PM_RUN` (everything clocked), `PM_IDLE` (the processor clock is stopped, while the peripheral clock and the oscillator keep running) and `PM_DOWN` (the peripheral clock and the oscillator are stopped too). `PM_RUN` moves to `PM_DOWN` on a power-down request. Otherwise it moves to `PM_IDLE` on an idle request. A power-down request wins when both requests arrive in the same cycle. `PM_IDLE` returns to `PM_RUN` when an enabled interrupt is pending. `PM_DOWN` has no exit except reset. A qualified reset, in any state, forces the next state to `PM_RUN`.

The raw reset pin becomes an internal reset only after it has been sampled high on two full machine cycles in a row. A machine cycle is twelve oscillator periods: six states of two phases each, taken from a divide-by-two of the oscillator. Any low sample restarts the count. While the block is asleep it forces fixed levels on the address-latch and program-strobe pins. It also tells port 0 to float when code is fetched from external memory. It blocks internal-RAM writes during the gap between a reset that ends idle and the point where the internal reset takes hold. When the first lock bit is set, the external-access pin is captured while reset is active and held afterwards.

Top module: `sleep_ctl`

## Requirements
- R1: `sys_rst` goes high only after `rst_pin` has been sampled high on 24 consecutive rising edges of `osc_clk`, which is two machine cycles. It becomes visible one cycle after the 24th high sample and stays high for (high samples − 23) cycles. With 23 samples it never asserts.
- R2: A single low sample of `rst_pin` restarts the qualification count. `sys_rst` falls on the second rising edge after `rst_pin` is first sampled low.
- R3: In `PM_IDLE`, `cpu_clk_en`=0 while `per_clk_en`=1 and `osc_run_en`=1.
- R4: In `PM_IDLE`, `irq_pend`=1 returns the block to `PM_RUN` on the next edge. `pd_req` has no effect in `PM_IDLE`.
- R5: From `PM_RUN`, `pd_req` enters `PM_DOWN` on the next edge, and it has priority over a simultaneous `idle_req`. In `PM_DOWN`, `cpu_clk_en`, `per_clk_en` and `osc_run_en` are all 0 while `rst_pin` is low.
- R6: In `PM_DOWN`, `irq_pend` and `idle_req` have no effect. Only a qualified reset leaves the state. `osc_run_en` follows `rst_pin` high at once so that the oscillator can restart for qualification.
- R7: `pin_hold`=1 in both sleep states. `ale_hold_lvl`=`psen_hold_lvl`=1 in `PM_IDLE` and 0 in `PM_DOWN`. In `PM_RUN`, `pin_hold`, `ale_hold_lvl` and `psen_hold_lvl` are all 0.
- R8: `p0_float`=1 exactly when the block is in a sleep state and `code_internal`=0. Here `code_internal`=1 means internal code execution.
- R9: With `code_lock`=1, `code_internal` takes the `ea_pin` level sampled while `sys_rst` is high and ignores later changes of the pin. With `code_lock`=0, `code_internal` follows `ea_pin` directly.
- R10: `ram_wr_block`=1 when the block is in `PM_IDLE` and `rst_pin` was sampled high on the previous edge. It is 0 in every other case.
- R11: While `sys_rst` is high the state is held at `PM_RUN`, and `idle_req` and `pd_req` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset of the block's own flops, active low |
| rst_pin | input | 1 | Raw external reset pin, active high |
| idle_req | input | 1 | Software request to enter idle (one-cycle pulse) |
| pd_req | input | 1 | Software request to enter power-down (one-cycle pulse) |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ea_pin | input | 1 | External-access pin level, 1 = internal code |
| code_lock | input | 1 | First lock bit programmed |
| sys_rst | output | 1 | Qualified internal reset |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run_en | output | 1 | Oscillator run enable |
| pin_hold | output | 1 | Address-latch and program-strobe pins are forced |
| ale_hold_lvl | output | 1 | Forced address-latch level |
| psen_hold_lvl | output | 1 | Forced program-strobe level |
| p0_float | output | 1 | Port 0 drivers released |
| ram_wr_block | output | 1 | Internal RAM writes inhibited |
| code_internal | output | 1 | Effective code-source level, 1 = internal |

## Verification
The assertions take `por_n` to be released while `rst_pin` is low. They also take `osc_clk` to keep toggling even while `osc_run_en` is low, so that the reset-pin counter in the checker sees every sample. The stimulus changes the inputs only on falling edges. It drives `idle_req` and `pd_req` as single-cycle pulses and holds `rst_pin` for whole, known counts of edges, so the checker's run-length counter and the bench's expected pulse lengths agree. The `ea_pin` capture is observed only after at least one qualified reset, because before that the captured value is undefined by design.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pm_state_t;

    // oscillator periods per machine cycle and machine cycles of reset qualification
    localparam int OSC_PER_MC = 12;
    localparam int QUAL_MC    = 2;
endpackage

// File: rtl/rst_qual.sv
module rst_qual #(
    parameter int OSC_PER_MC = 12,
    parameter int QUAL_MC    = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    output logic pin_seen,
    output logic sys_rst
);
    localparam int LIM = OSC_PER_MC * QUAL_MC;
    localparam int CW  = $clog2(LIM + 1);

    logic          pin_q;
    logic [CW-1:0] run_cnt;

    // run-length of consecutive high samples, saturating at the limit
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pin_q   <= 1'b0;
            run_cnt <= '0;
        end else begin
            pin_q <= rst_pin;
            if (!pin_q)
                run_cnt <= '0;
            else if (run_cnt != CW'(LIM))
                run_cnt <= run_cnt + 1'b1;
        end
    end

    assign pin_seen = pin_q;
    assign sys_rst  = (run_cnt == CW'(LIM));
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import sleep_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      sys_rst,
    input  logic      idle_req,
    input  logic      pd_req,
    input  logic      irq_pend,
    output pm_state_t state,
    output logic      cpu_en,
    output logic      per_en,
    output logic      osc_keep,
    output logic      hold,
    output logic      ale_lvl,
    output logic      psen_lvl
);
    pm_state_t nxt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= PM_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PM_RUN: begin
                if (pd_req)        nxt = PM_DOWN;
                else if (idle_req) nxt = PM_IDLE;
            end
            PM_IDLE: if (irq_pend) nxt = PM_RUN;
            PM_DOWN: nxt = PM_DOWN;
            default: nxt = PM_RUN;
        endcase
        if (sys_rst) nxt = PM_RUN;
    end

    always_comb begin
        cpu_en   = 1'b0;
        per_en   = 1'b0;
        osc_keep = 1'b0;
        hold     = 1'b0;
        ale_lvl  = 1'b0;
        psen_lvl = 1'b0;
        unique case (state)
            PM_RUN: begin
                cpu_en   = 1'b1;
                per_en   = 1'b1;
                osc_keep = 1'b1;
            end
            PM_IDLE: begin
                per_en   = 1'b1;
                osc_keep = 1'b1;
                hold     = 1'b1;
                ale_lvl  = 1'b1;
                psen_lvl = 1'b1;
            end
            PM_DOWN: hold = 1'b1;
            default: cpu_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_capture.sv
module ea_capture (
    input  logic clk,
    input  logic sys_rst,
    input  logic ea_pin,
    input  logic code_lock,
    output logic code_internal
);
    // deliberately no power-on reset: the held level is defined only after a qualified reset
    logic ea_held;

    always_ff @(posedge clk) begin
        if (sys_rst) ea_held <= ea_pin;
    end

    assign code_internal = code_lock ? ea_held : ea_pin;
endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
    import sleep_pkg::*;
#(
    parameter int MC_OSC  = OSC_PER_MC,
    parameter int MC_QUAL = QUAL_MC
) (
    input  logic osc_clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic idle_req,
    input  logic pd_req,
    input  logic irq_pend,
    input  logic ea_pin,
    input  logic code_lock,
    output logic sys_rst,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_run_en,
    output logic pin_hold,
    output logic ale_hold_lvl,
    output logic psen_hold_lvl,
    output logic p0_float,
    output logic ram_wr_block,
    output logic code_internal
);
    pm_state_t state;
    logic      pin_seen;
    logic      osc_keep;

    rst_qual #(.OSC_PER_MC(MC_OSC), .QUAL_MC(MC_QUAL)) i_qual (
        .clk      (osc_clk),
        .por_n    (por_n),
        .rst_pin  (rst_pin),
        .pin_seen (pin_seen),
        .sys_rst  (sys_rst)
    );

    pm_fsm i_fsm (
        .clk      (osc_clk),
        .por_n    (por_n),
        .sys_rst  (sys_rst),
        .idle_req (idle_req),
        .pd_req   (pd_req),
        .irq_pend (irq_pend),
        .state    (state),
        .cpu_en   (cpu_clk_en),
        .per_en   (per_clk_en),
        .osc_keep (osc_keep),
        .hold     (pin_hold),
        .ale_lvl  (ale_hold_lvl),
        .psen_lvl (psen_hold_lvl)
    );

    ea_capture i_ea (
        .clk           (osc_clk),
        .sys_rst       (sys_rst),
        .ea_pin        (ea_pin),
        .code_lock     (code_lock),
        .code_internal (code_internal)
    );

    // a high reset pin restarts the oscillator so the qualifier can count
    assign osc_run_en   = osc_keep | rst_pin;
    assign p0_float     = (state != PM_RUN) & ~code_internal;
    assign ram_wr_block = (state == PM_IDLE) & pin_seen;
endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk #(
    parameter int QUAL = 24
) (
    input logic osc_clk,
    input logic por_n,
    input logic rst_pin,
    input logic irq_pend,
    input logic sys_rst,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic osc_run_en,
    input logic pin_hold,
    input logic ale_hold_lvl,
    input logic psen_hold_lvl
);
    localparam int HW = $clog2(QUAL + 1);
    logic [HW-1:0] hi_run;

    always_ff @(posedge osc_clk or negedge por_n) begin
        if (!por_n)                   hi_run <= '0;
        else if (!rst_pin)            hi_run <= '0;
        else if (hi_run != HW'(QUAL)) hi_run <= hi_run + 1'b1;
    end

    assert_qualified_run_R1: assert property (@(posedge osc_clk) disable iff (!por_n)
        $rose(sys_rst) |-> ($past(hi_run) == HW'(QUAL)));

    assert_idle_keeps_osc_R3: assert property (@(posedge osc_clk) disable iff (!por_n)
        (!cpu_clk_en && per_clk_en) |-> osc_run_en);

    assert_irq_wakes_idle_R4: assert property (@(posedge osc_clk) disable iff (!por_n)
        (!cpu_clk_en && per_clk_en && irq_pend && !sys_rst) |=> cpu_clk_en);

    assert_down_stops_osc_R5: assert property (@(posedge osc_clk) disable iff (!por_n)
        (!per_clk_en && !rst_pin) |-> (!osc_run_en && !cpu_clk_en));

    assert_down_sticky_R6: assert property (@(posedge osc_clk) disable iff (!por_n)
        (!per_clk_en && !sys_rst) |=> !per_clk_en);

    assert_idle_pins_high_R7: assert property (@(posedge osc_clk) disable iff (!por_n)
        (pin_hold && per_clk_en) |-> (ale_hold_lvl && psen_hold_lvl));

    assert_down_pins_low_R7: assert property (@(posedge osc_clk) disable iff (!por_n)
        (pin_hold && !per_clk_en) |-> (!ale_hold_lvl && !psen_hold_lvl));

    assert_reset_forces_run_R11: assert property (@(posedge osc_clk) disable iff (!por_n)
        sys_rst |=> cpu_clk_en);
endmodule

bind sleep_ctl sleep_ctl_chk #(.QUAL(MC_OSC * MC_QUAL)) i_chk (
    .osc_clk       (osc_clk),
    .por_n         (por_n),
    .rst_pin       (rst_pin),
    .irq_pend      (irq_pend),
    .sys_rst       (sys_rst),
    .cpu_clk_en    (cpu_clk_en),
    .per_clk_en    (per_clk_en),
    .osc_run_en    (osc_run_en),
    .pin_hold      (pin_hold),
    .ale_hold_lvl  (ale_hold_lvl),
    .psen_hold_lvl (psen_hold_lvl)
);

// File: tb/test_sleep_ctl.sv
module test_sleep_ctl;
    localparam int CLK_P = 10;

    logic osc_clk = 1'b0;
    logic por_n, rst_pin, idle_req, pd_req, irq_pend, ea_pin, code_lock;
    logic sys_rst, cpu_clk_en, per_clk_en, osc_run_en, pin_hold;
    logic ale_hold_lvl, psen_hold_lvl, p0_float, ram_wr_block, code_internal;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) osc_clk = ~osc_clk;

    sleep_ctl i_sleep_ctl (
        .osc_clk(osc_clk), .por_n(por_n), .rst_pin(rst_pin),
        .idle_req(idle_req), .pd_req(pd_req), .irq_pend(irq_pend),
        .ea_pin(ea_pin), .code_lock(code_lock),
        .sys_rst(sys_rst), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_run_en(osc_run_en), .pin_hold(pin_hold),
        .ale_hold_lvl(ale_hold_lvl), .psen_hold_lvl(psen_hold_lvl),
        .p0_float(p0_float), .ram_wr_block(ram_wr_block),
        .code_internal(code_internal)
    );

    // {idle_req, pd_req, irq_pend, cpu, per, osc, hold, ale, psen}
    localparam logic [8:0] VEC [8] = '{
        9'b100_011_111,  // R3 R7 enter idle
        9'b000_011_111,  // stay idle
        9'b010_011_111,  // R4 power-down request ignored in idle
        9'b001_111_000,  // R4 interrupt wakes
        9'b001_111_000,  // interrupt in run: no change
        9'b110_000_100,  // R5 both requests, power-down wins
        9'b001_000_100,  // R6 interrupt ignored in power-down
        9'b100_000_100   // R6 idle request ignored in power-down
    };

    task automatic tick();
        @(posedge osc_clk);
        @(negedge osc_clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_count(input int hi, output int seen);
        seen = 0;
        rst_pin = 1'b1;
        for (int k = 0; k < hi; k++) begin tick(); seen += int'(sys_rst); end
        rst_pin = 1'b0;
        for (int k = 0; k < 4; k++) begin tick(); seen += int'(sys_rst); end
    endtask

    task automatic full_reset();
        int dummy;
        pulse_count(30, dummy);
    endtask

    initial begin
        repeat (100000) @(posedge osc_clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seen;
        por_n = 1'b0; rst_pin = 1'b0; idle_req = 1'b0; pd_req = 1'b0;
        irq_pend = 1'b0; ea_pin = 1'b1; code_lock = 1'b0;
        repeat (3) tick();
        por_n = 1'b1;
        tick();
        chk("R7 reset-state outputs", {sys_rst, cpu_clk_en, per_clk_en, osc_run_en, pin_hold},
            5'b01110);

        for (int i = 0; i < 8; i++) begin
            {idle_req, pd_req, irq_pend} = VEC[i][8:6];
            tick();
            idle_req = 1'b0; pd_req = 1'b0; irq_pend = 1'b0;
            chk($sformatf("R3/R4/R5/R6/R7 vector %0d", i),
                {cpu_clk_en, per_clk_en, osc_run_en, pin_hold, ale_hold_lvl, psen_hold_lvl},
                {26'd0, VEC[i][5:0]});
        end

        // R6: in power-down, the reset pin restarts the oscillator and reset exits
        rst_pin = 1'b1;
        #1 chk("R6 oscillator restarts on reset pin", osc_run_en, 1);
        repeat (30) tick();
        rst_pin = 1'b0;
        repeat (3) tick();
        chk("R6 reset leaves power-down", {cpu_clk_en, per_clk_en, pin_hold}, 3'b110);

        // R1 / R2: qualification length
        pulse_count(23, seen); chk("R1 23 high samples give no reset", seen, 0);
        pulse_count(24, seen); chk("R1 24 high samples give one cycle", seen, 1);
        pulse_count(30, seen); chk("R1 30 high samples give seven cycles", seen, 7);
        seen = 0;
        rst_pin = 1'b1; for (int k = 0; k < 20; k++) begin tick(); seen += int'(sys_rst); end
        rst_pin = 1'b0; tick(); seen += int'(sys_rst);
        rst_pin = 1'b1; for (int k = 0; k < 20; k++) begin tick(); seen += int'(sys_rst); end
        rst_pin = 1'b0; for (int k = 0; k < 4; k++) begin tick(); seen += int'(sys_rst); end
        chk("R2 low sample restarts count", seen, 0);
        rst_pin = 1'b1; repeat (26) tick();
        rst_pin = 1'b0; tick();
        chk("R2 reset still high one edge after drop", sys_rst, 1);
        tick();
        chk("R2 reset falls on second edge", sys_rst, 0);

        // R11: requests ignored during reset
        rst_pin = 1'b1; repeat (26) tick();
        idle_req = 1'b1; pd_req = 1'b1; tick();
        idle_req = 1'b0; pd_req = 1'b0; tick();
        chk("R11 requests ignored under reset", {sys_rst, cpu_clk_en, pin_hold}, 3'b110);
        rst_pin = 1'b0; repeat (3) tick();

        // R10: reset pin seen while idle blocks RAM writes
        idle_req = 1'b1; tick(); idle_req = 1'b0;
        chk("R10 no block in idle without reset pin", ram_wr_block, 0);
        rst_pin = 1'b1; tick();
        chk("R10 block once pin sampled in idle", {ram_wr_block, cpu_clk_en}, 2'b10);
        repeat (26) tick();
        rst_pin = 1'b0; repeat (3) tick();
        chk("R10 block clears after reset returns to run", {ram_wr_block, cpu_clk_en}, 2'b01);

        // R9 / R8: external-access capture and port 0 release
        code_lock = 1'b1; ea_pin = 1'b0;
        full_reset();
        ea_pin = 1'b1; tick();
        chk("R9 locked level held after reset", code_internal, 0);
        chk("R8 port 0 driven in run", p0_float, 0);
        idle_req = 1'b1; tick(); idle_req = 1'b0;
        chk("R8 port 0 floats in idle with external code", p0_float, 1);
        irq_pend = 1'b1; tick(); irq_pend = 1'b0;
        code_lock = 1'b0; #1;
        chk("R9 unlocked follows pin high", code_internal, 1);
        ea_pin = 1'b0; #1;
        chk("R9 unlocked follows pin low", code_internal, 0);
        ea_pin = 1'b1; tick();
        pd_req = 1'b1; tick(); pd_req = 1'b0;
        chk("R8 port 0 kept in power-down with internal code", p0_float, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule